// File: doc/BRIEF.md
# Keyed Windowed Deadman Timer

This block is a supervisory timer with a small register bus. When software turns it on, a counter advances once per clock. If the counter reaches the last count of its period, the block raises a one-cycle reset request and sets a sticky reset-cause flag. To keep the system alive, software must clear the counter with a two-step key sequence. The first key arms the sequence. The second key is accepted only while the clear window is open, which is the final stretch of the period. A wrong key, a second key with no armed first key, or a second key sent while the window is closed is an error. An error sets a status flag and raises the same one-cycle request as an expiry.

The key sequence is tracked by a four-state machine:
- `ST_OFF`: timer disabled.
- `ST_IDLE`: running, no key taken.
- `ST_ARMED`: running, first key taken.
- `ST_HOLD`: the single cycle after a disable, during which the bus is deaf.

The transitions are:
- ENABLE (`ST_OFF` to `ST_IDLE`) on an enable write.
- ARM (`ST_IDLE` to `ST_ARMED`) on a correct first key.
- CLEAR (`ST_ARMED` to `ST_IDLE`) on a correct second key in the window.
- ABORT (`ST_ARMED` to `ST_IDLE`) on any other second key, a bad first key or an expiry.
- DISABLE (`ST_IDLE` or `ST_ARMED` to `ST_HOLD`) on a disable write.
- RELEASE (`ST_HOLD` to `ST_OFF`) unconditionally one cycle later.

The period and window length are build-time parameters, and software can read both back. Register offsets are:
- 0x00: control.
- 0x10: first key.
- 0x20: second key.
- 0x30: status.
- 0x40: counter.
- 0x60: period.
- 0x70: window.
- 0x80: reset cause.

A clear alias sits at base+0x4, and the control register also has a set alias at base+0x8. Writes take effect at the clock edge where `bus_wr` is sampled high. A read returns, one cycle later on `bus_rdata`, the register value as it stood before that edge.

Top module: `keyed_deadman`

## Requirements
- R1: After reset the block is disabled. Control, status, counter and cause all read 0, `bus_rdata` is 0 and `trip_o` is low.
- R2: Enable and disable work as follows:
  - Writing bit 15 = 1 to 0x08 enables the timer.
  - Writing bit 15 = 1 to 0x04 disables it.
  - A write to 0x00 loads the enable from bit 15.
  - Control bit 15 reads back the enable state.
  - While disabled, the counter reads 0.
- R3: While enabled, the counter (read at 0x40) rises by one per clock. At count PERIOD-1 it expires and returns to 0 on the next edge, unless a valid clear lands on that edge.
- R4: Status bit 0 is 1 exactly while the timer is enabled and the counter is at least PERIOD-WINDOW.
- R5: Writing 0x40 in bits 15:8 of 0x10, then 0x08 in bits 7:0 of 0x20 while the window is open, zeroes the counter. No flag is set and `trip_o` stays low.
- R6: A first-key write whose bits 15:8 are not 0x40 sets status bit 7 (bad first key) and bit 5 (event). It also pulses `trip_o` high for the one cycle after the write edge.
- R7: The following second-key writes set status bit 6 (bad second key) and bit 5, and pulse `trip_o`:
  - a wrong value;
  - a value with no armed first key;
  - a value written while the window is closed.
- R8: On expiry, `trip_o` pulses for one cycle, status bit 5 sets, and bit 5 of the cause register at 0x80 sets. The cause bit stays set until a write with bit 5 set goes to 0x84.
- R9: Writing to 0x34 clears each status bit 7, 6 or 5 that is 1 in the write data. The cause register is left alone.
- R10: In the cycle right after the enable is cleared, the block ignores bus writes and reads, and `bus_rdata` holds its previous value.
- R11: Reads return PERIOD at 0x60 and WINDOW at 0x70. The key registers 0x10 and 0x20 read 0.
- R12: While disabled, key writes set no flag, and the block never raises `trip_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the counter and registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after `bus_rd` |
| trip_o | output | 1 | One-cycle reset request on expiry or key error |

## Verification
Every write takes effect at the edge that samples it, so the bench checks flags, `trip_o` and the enable state in the half cycle after that edge. Read data is registered and shows the state from before its sampling edge. The bench therefore models the counter as the number of edges since the last enable or valid clear, modulo PERIOD, and compares each read against the value one edge before the read edge. It predicts expiry to arrive exactly PERIOD edges after that reference, and it places second keys by counting edges into the window, never by reading the design.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_ARMED = 2'd2,
        ST_HOLD  = 2'd3
    } dmt_state_e;

    typedef struct packed {
        logic bad1;
        logic bad2;
        logic evt;
    } dmt_flags_t;

    // register offsets
    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_KEY1  = 8'h10;
    localparam logic [7:0] OFS_KEY2  = 8'h20;
    localparam logic [7:0] OFS_STAT  = 8'h30;
    localparam logic [7:0] OFS_CNT   = 8'h40;
    localparam logic [7:0] OFS_PER   = 8'h60;
    localparam logic [7:0] OFS_WIN   = 8'h70;
    localparam logic [7:0] OFS_CAUSE = 8'h80;
    localparam logic [7:0] ALIAS_CLR = 8'h04;
    localparam logic [7:0] ALIAS_SET = 8'h08;

    // key values and bit positions
    localparam logic [7:0] KEY1_VAL  = 8'h40;
    localparam logic [7:0] KEY2_VAL  = 8'h08;
    localparam int EN_BIT    = 15;
    localparam int ST_WIN    = 0;
    localparam int ST_EVT    = 5;
    localparam int ST_BAD2   = 6;
    localparam int ST_BAD1   = 7;
    localparam int CAUSE_BIT = 5;

endpackage

// File: rtl/dmt_counter.sv
module dmt_counter #(
    parameter int CNT_W  = 16,
    parameter int PERIOD = 64,
    parameter int WINDOW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    output logic [CNT_W-1:0] count,
    output logic             win_open,
    output logic             expire
);
    localparam logic [CNT_W-1:0] LAST      = CNT_W'(PERIOD - 1);
    localparam logic [CNT_W-1:0] WIN_START = CNT_W'(PERIOD - WINDOW);

    generate
        if (WINDOW < 1 || WINDOW >= PERIOD || PERIOD > (1 << CNT_W)) begin : g_bad_cfg
            $error("dmt_counter: WINDOW must be in 1..PERIOD-1 and PERIOD must fit CNT_W");
        end
    endgenerate

    assign win_open = run && (count >= WIN_START);
    assign expire   = run && !clr && (count == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    count <= '0;
        else if (!run || clr || expire) count <= '0;
        else                           count <= count + 1'b1;
    end

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LAST);
    p_expire_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (count == '0));
    p_stopped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (count == '0));

endmodule

// File: rtl/dmt_keyfsm.sv
module dmt_keyfsm
    import dmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_set,
    input  logic       ctl_clr,
    input  logic       key1_wr,
    input  logic       key1_ok,
    input  logic       key2_wr,
    input  logic       key2_ok,
    input  logic       win_open,
    input  logic       expire,
    input  dmt_flags_t stat_clr,
    input  logic       cause_clr,
    output logic       enabled,
    output logic       hold,
    output logic       cnt_clr,
    output dmt_flags_t flags,
    output logic       cause,
    output logic       trip
);
    dmt_state_e state, state_nx;
    logic       bad1, bad2;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:   if (ctl_set) state_nx = ST_IDLE;
            ST_IDLE: begin
                if (ctl_clr)                 state_nx = ST_HOLD;
                else if (key1_wr && key1_ok) state_nx = ST_ARMED;
            end
            ST_ARMED: begin
                if (ctl_clr)                          state_nx = ST_HOLD;
                else if (key2_wr || bad1 || expire)   state_nx = ST_IDLE;
            end
            ST_HOLD:  state_nx = ST_OFF;
            default:  state_nx = ST_OFF;
        endcase
    end

    // decoded outputs
    always_comb begin
        enabled = 1'b0;
        hold    = 1'b0;
        cnt_clr = 1'b0;
        unique case (state)
            ST_OFF:   ;
            ST_IDLE:  enabled = 1'b1;
            ST_ARMED: begin
                enabled = 1'b1;
                cnt_clr = key2_wr && key2_ok && win_open;
            end
            ST_HOLD:  hold = 1'b1;
            default:  ;
        endcase
        bad1 = enabled && key1_wr && !key1_ok;
        bad2 = enabled && key2_wr && !cnt_clr;
    end

    // sticky flags and trip pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
            cause <= 1'b0;
            trip  <= 1'b0;
        end else begin
            flags.bad1 <= bad1 | (flags.bad1 & ~stat_clr.bad1);
            flags.bad2 <= bad2 | (flags.bad2 & ~stat_clr.bad2);
            flags.evt  <= bad1 | bad2 | expire | (flags.evt & ~stat_clr.evt);
            cause      <= expire | (cause & ~cause_clr);
            trip       <= bad1 | bad2 | expire;
        end
    end

    p_hold_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |=> (state == ST_OFF));
    p_bad1_trip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && key1_wr && !key1_ok) |=> (trip && flags.bad1 && flags.evt));
    p_cause_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cause && !cause_clr) |=> cause);
    p_off_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |=> !trip);
    p_clear_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_clr && !key1_wr) |=> !trip);

endmodule

// File: rtl/dmt_regbus.sv
module dmt_regbus
    import dmt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int PERIOD = 64,
    parameter int WINDOW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              hold,
    input  logic              enabled,
    input  dmt_flags_t        flags,
    input  logic              win_open,
    input  logic [CNT_W-1:0]  count,
    input  logic              cause,
    output logic [DATA_W-1:0] rdata,
    output logic              ctl_set,
    output logic              ctl_clr,
    output logic              key1_wr,
    output logic              key1_ok,
    output logic              key2_wr,
    output logic              key2_ok,
    output dmt_flags_t        stat_clr,
    output logic              cause_clr
);
    logic              wr;
    logic [DATA_W-1:0] rd_val;
    logic              unused_bits;

    assign unused_bits = ^wdata[DATA_W-1:16];
    assign wr          = wr_en && !hold;

    always_comb begin
        ctl_set   = wr && wdata[EN_BIT] &&
                    (addr == ADDR_W'(OFS_CTRL) || addr == ADDR_W'(OFS_CTRL | ALIAS_SET));
        ctl_clr   = wr && ((addr == ADDR_W'(OFS_CTRL) && !wdata[EN_BIT]) ||
                           (addr == ADDR_W'(OFS_CTRL | ALIAS_CLR) && wdata[EN_BIT]));
        key1_wr   = wr && (addr == ADDR_W'(OFS_KEY1));
        key1_ok   = (wdata[15:8] == KEY1_VAL);
        key2_wr   = wr && (addr == ADDR_W'(OFS_KEY2));
        key2_ok   = (wdata[7:0] == KEY2_VAL);
        stat_clr  = '0;
        if (wr && addr == ADDR_W'(OFS_STAT | ALIAS_CLR)) begin
            stat_clr.bad1 = wdata[ST_BAD1];
            stat_clr.bad2 = wdata[ST_BAD2];
            stat_clr.evt  = wdata[ST_EVT];
        end
        cause_clr = wr && (addr == ADDR_W'(OFS_CAUSE | ALIAS_CLR)) && wdata[CAUSE_BIT];
    end

    always_comb begin
        rd_val = '0;
        unique case (addr)
            ADDR_W'(OFS_CTRL):  rd_val[EN_BIT] = enabled;
            ADDR_W'(OFS_STAT): begin
                rd_val[ST_WIN]  = win_open;
                rd_val[ST_EVT]  = flags.evt;
                rd_val[ST_BAD2] = flags.bad2;
                rd_val[ST_BAD1] = flags.bad1;
            end
            ADDR_W'(OFS_CNT):   rd_val = DATA_W'(count);
            ADDR_W'(OFS_PER):   rd_val = DATA_W'(PERIOD);
            ADDR_W'(OFS_WIN):   rd_val = DATA_W'(WINDOW);
            ADDR_W'(OFS_CAUSE): rd_val[CAUSE_BIT] = cause;
            default:            rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              rdata <= '0;
        else if (rd_en && !hold) rdata <= rd_val;
    end

    p_hold_rdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(rdata));
    p_hold_nostrobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !(ctl_set || ctl_clr || key1_wr || key2_wr || cause_clr));

endmodule

// File: rtl/keyed_deadman.sv
module keyed_deadman
    import dmt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int PERIOD = 64,
    parameter int WINDOW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              trip_o
);
    logic             ctl_set, ctl_clr, key1_wr, key1_ok, key2_wr, key2_ok, cause_clr;
    logic             enabled, hold, cnt_clr, cause, win_open, expire;
    logic [CNT_W-1:0] count;
    dmt_flags_t       flags, stat_clr;

    dmt_regbus #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
        .PERIOD(PERIOD), .WINDOW(WINDOW)
    ) u_bus (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .rd_en(bus_rd),
        .addr(bus_addr), .wdata(bus_wdata), .hold(hold), .enabled(enabled),
        .flags(flags), .win_open(win_open), .count(count), .cause(cause),
        .rdata(bus_rdata), .ctl_set(ctl_set), .ctl_clr(ctl_clr),
        .key1_wr(key1_wr), .key1_ok(key1_ok), .key2_wr(key2_wr), .key2_ok(key2_ok),
        .stat_clr(stat_clr), .cause_clr(cause_clr)
    );

    dmt_keyfsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctl_set(ctl_set), .ctl_clr(ctl_clr),
        .key1_wr(key1_wr), .key1_ok(key1_ok), .key2_wr(key2_wr), .key2_ok(key2_ok),
        .win_open(win_open), .expire(expire), .stat_clr(stat_clr),
        .cause_clr(cause_clr), .enabled(enabled), .hold(hold), .cnt_clr(cnt_clr),
        .flags(flags), .cause(cause), .trip(trip_o)
    );

    dmt_counter #(
        .CNT_W(CNT_W), .PERIOD(PERIOD), .WINDOW(WINDOW)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(enabled), .clr(cnt_clr),
        .count(count), .win_open(win_open), .expire(expire)
    );

    p_trip_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(expire) && !$past(enabled && (key1_wr || key2_wr))) |-> (trip_o && cause));

endmodule

// File: tb/sim_keyed_deadman.sv
module sim_keyed_deadman;
    localparam int CLK_PERIOD = 10;
    localparam int P = 64;
    localparam int W = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        trip_o;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;
    int base = 0;
    logic last_trip;
    logic [31:0] rd;

    keyed_deadman #(.ADDR_W(8), .DATA_W(32), .CNT_W(16), .PERIOD(P), .WINDOW(W)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .trip_o(trip_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
        last_trip = trip_o;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] exp_cnt();
        return 32'((cyc - 1 - base) % P);
    endfunction

    function automatic logic exp_win();
        return ((cyc - 1 - base) % P) >= (P - W);
    endfunction

    function automatic logic [31:0] stat_word(input logic b1, input logic b2,
                                              input logic ev, input logic win);
        return {24'b0, b1, b2, ev, 4'b0, win};
    endfunction

    task automatic wait_window();
        while (((cyc - base) % P) < (P - W)) @(negedge clk);
    endtask

    task automatic good_clear();
        bus_write(8'h10, {16'($urandom), 8'h40, 8'($urandom)});
        wait_window();
        bus_write(8'h20, {24'($urandom), 8'h08});
        base = cyc;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 trip", 32'(trip_o), 0);
        check("R1 rdata", bus_rdata, 0);
        bus_read(8'h00, rd); check("R1 ctrl", rd, 0);
        bus_read(8'h30, rd); check("R1 status", rd, 0);
        bus_read(8'h40, rd); check("R1 count", rd, 0);
        bus_read(8'h80, rd); check("R1 cause", rd, 0);
        // R11 read-only values
        bus_read(8'h60, rd); check("R11 period", rd, P);
        bus_read(8'h70, rd); check("R11 window", rd, W);
        bus_read(8'h10, rd); check("R11 key1 reads zero", rd, 0);
        bus_read(8'h20, rd); check("R11 key2 reads zero", rd, 0);

        // R12 keys ignored while disabled
        bus_write(8'h10, 32'h0000_1234); check("R12 trip key1", 32'(last_trip), 0);
        bus_write(8'h20, 32'h0000_0055); check("R12 trip key2", 32'(last_trip), 0);
        bus_read(8'h30, rd); check("R12 status", rd, 0);

        // R2 enable through set alias
        bus_write(8'h08, 32'h0000_8000); base = cyc;
        bus_read(8'h00, rd); check("R2 ctrl on", rd, 32'h8000);

        // R3 counter progress
        for (int i = 0; i < 4; i++) begin
            repeat ($urandom_range(1, 9)) @(negedge clk);
            bus_read(8'h40, rd); check("R3 count", rd, exp_cnt());
        end

        // R4 window open, R5 valid clear
        wait_window();
        bus_read(8'h30, rd); check("R4 window bit", rd, stat_word(0, 0, 0, exp_win()));
        good_clear();
        check("R5 no trip", 32'(last_trip), 0);
        bus_read(8'h40, rd); check("R5 count zero", rd, exp_cnt());
        bus_read(8'h30, rd); check("R5 status", rd, stat_word(0, 0, 0, exp_win()));

        // R8 expiry
        begin
            int lim = 0;
            while (!trip_o && lim < 3 * P) begin @(negedge clk); lim++; end
        end
        check("R8 expiry edge", 32'(cyc), 32'(base + P));
        base = base + P;
        bus_read(8'h30, rd); check("R8 event flag", rd, stat_word(0, 0, 1, exp_win()));
        check("R8 trip one cycle", 32'(trip_o), 0);
        bus_read(8'h80, rd); check("R8 cause set", rd, 32'h20);
        bus_read(8'h40, rd); check("R3 wrap count", rd, exp_cnt());

        // R9 status clear leaves cause alone
        bus_write(8'h34, 32'h0000_00E0);
        bus_read(8'h30, rd); check("R9 status cleared", rd, stat_word(0, 0, 0, exp_win()));
        bus_read(8'h80, rd); check("R8 cause sticky", rd, 32'h20);
        bus_write(8'h84, 32'h0000_0020);
        bus_read(8'h80, rd); check("R8 cause cleared", rd, 0);

        // R6 / R7 random key scenarios
        for (int it = 0; it < 40; it++) begin
            int sc;
            good_clear();
            bus_write(8'h34, 32'h0000_00E0);
            sc = $urandom_range(0, 4);
            case (sc)
                0: begin
                    good_clear();
                    check("R5 rand no trip", 32'(last_trip), 0);
                    bus_read(8'h40, rd); check("R5 rand count", rd, exp_cnt());
                    bus_read(8'h30, rd); check("R5 rand status", rd, stat_word(0, 0, 0, exp_win()));
                end
                1: begin
                    do v = 8'($urandom); while (v == 8'h40);
                    bus_write(8'h10, {16'($urandom), v, 8'($urandom)});
                    check("R6 bad key1 trip", 32'(last_trip), 1);
                    bus_read(8'h30, rd); check("R6 bad key1 status", rd, stat_word(1, 0, 1, exp_win()));
                end
                2: begin
                    bus_write(8'h10, 32'h0000_4000);
                    wait_window();
                    do v = 8'($urandom); while (v == 8'h08);
                    bus_write(8'h20, {24'($urandom), v});
                    check("R7 wrong key2 trip", 32'(last_trip), 1);
                    bus_read(8'h30, rd); check("R7 wrong key2 status", rd, stat_word(0, 1, 1, exp_win()));
                end
                3: begin
                    bus_write(8'h20, 32'h0000_0008);
                    check("R7 unarmed key2 trip", 32'(last_trip), 1);
                    bus_read(8'h30, rd); check("R7 unarmed key2 status", rd, stat_word(0, 1, 1, exp_win()));
                end
                default: begin
                    bus_write(8'h10, 32'h0000_4000);
                    bus_write(8'h20, 32'h0000_0008);
                    check("R7 closed window trip", 32'(last_trip), 1);
                    bus_read(8'h30, rd); check("R7 closed window status", rd, stat_word(0, 1, 1, exp_win()));
                    bus_read(8'h40, rd); check("R7 count kept", rd, exp_cnt());
                end
            endcase
        end

        // R10 bus ignored in the cycle after disable
        bus_read(8'h00, rd); check("R2 ctrl still on", rd, 32'h8000);
        bus_write(8'h04, 32'h0000_8000);
        bus_read(8'h40, rd); check("R10 read ignored", rd, 32'h8000);
        bus_read(8'h00, rd); check("R2 ctrl off", rd, 0);
        bus_write(8'h08, 32'h0000_8000);
        bus_write(8'h00, 32'h0000_0000);
        bus_write(8'h08, 32'h0000_8000);
        bus_read(8'h00, rd); check("R10 set ignored", rd, 0);
        bus_read(8'h40, rd); check("R2 count zero off", rd, 0);
        begin
            logic seen = 1'b0;
            repeat (2 * P) begin @(negedge clk); if (trip_o) seen = 1'b1; end
            check("R12 no trip disabled", 32'(seen), 0);
        end
        bus_write(8'h00, 32'h0000_8000);
        bus_read(8'h00, rd); check("R2 base write enable", rd, 32'h8000);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule